// File: doc/BRIEF.md
# Priority Vectored Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral sources and from one external standard interrupt pin. It drives the processor's normal interrupt line and hands software a vector that names the winning source. A second, fast interrupt line is kept apart from all of this. Only a dedicated external pin drives it, after a two-stage synchroniser.

Each source has an enable bit, a 3-bit priority and a sensitivity setting. Internal sources are either active-high level or rising edge. The external source can be high level, low level, rising edge or falling edge. The external pin passes through a two-stage synchroniser before detection.

Software works through a small register port. One read of the vector address returns the winner and acknowledges it. That read clears the winner's latched edge and puts the controller in service, which holds the normal line low. A later end-of-interrupt write leaves service, and the line is then re-evaluated from the current pending state. Only one level of service is held. The register port is a plain single-cycle strobe interface with no back-pressure. A read strobe is accepted in the cycle it is high, and its data appears on `reg_rdata` after that clock edge.

Top module: `pvic_top`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low. The enable register, every priority and every sensitivity setting read back as zero.
- R2: `fiq_o` equals `ext_fiq_i` delayed by two clock edges. No internal source, whatever its state or setting, ever raises `fiq_o`.
- R3: A source whose enable bit is 0 never raises `irq_o`. Setting the bit while that source is pending raises `irq_o` in the cycle after the write edge.
- R4: An internal source in level mode (sensitivity bit 5 = 0) is pending exactly while its input is high. Dropping the input drops `irq_o` with no clock edge in between.
- R5: An internal source in edge mode (sensitivity bit 5 = 1) latches pending on a rising edge of its input. It stays pending after the input falls, until the source is acknowledged.
- R6: The external source is source index NUM_INT (index 7 by default). Its two sensitivity bits [5:4] select the mode: 00 high level, 01 low level, 10 rising edge, 11 falling edge. A pin change reaches level detection after two clock edges and latches an edge after three.
- R7: Among enabled pending sources, the one with the numerically highest priority wins (7 is the highest).
- R8: Among enabled pending sources of equal highest priority, the lowest source index wins.
- R9: A read of address 2 while `irq_o` is high returns bit 7 = 1 and the winner's index in bits [2:0]. It clears that source's latched edge and holds `irq_o` low from the next cycle. A read of address 2 while `irq_o` is low returns 0x00 and changes nothing.
- R10: A write to address 3 (end of interrupt) leaves service. From the cycle after that edge, `irq_o` is high again if any enabled source is still pending.
- R11: Address 0 holds the enable bits, bit i for source i. Address 8+i holds source i's priority in bits [2:0] and its sensitivity in bits [5:4]. Bit 4 is forced to 0 for internal sources. Both read back through `reg_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_req_i | input | NUM_INT | Internal peripheral requests, synchronous to clk |
| ext_irq_i | input | 1 | External standard interrupt pin (asynchronous) |
| ext_fiq_i | input | 1 | External fast interrupt pin (asynchronous) |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, registered on the read edge |
| irq_o | output | 1 | Normal interrupt request to the processor |
| fiq_o | output | 1 | Fast interrupt request to the processor |

## Verification
A lost or stuck pending bit shows at the ports at once. Either `irq_o` stays high after an edge source has been acknowledged, or it never rises after an edge. The vector read that follows at most one cycle later names the wrong index. A faulty arbiter shows as a wrong vector on the first read that has two sources pending. A faulty service flag shows as `irq_o` failing to drop the cycle after an acknowledge, or failing to return the cycle after an end-of-interrupt. Synchroniser faults show as `fiq_o`, or the external level response, arriving one edge early or late.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;
  localparam int PRIO_W = 3;

  localparam logic [ADDR_W-1:0] ADDR_ENABLE = 4'd0;
  localparam logic [ADDR_W-1:0] ADDR_VECTOR = 4'd2;
  localparam logic [ADDR_W-1:0] ADDR_EOI    = 4'd3;

  // sensitivity: trig=1 edge, inv=1 low level / falling edge
  typedef struct packed {
    logic trig;
    logic inv;
  } sense_t;
endpackage

// File: rtl/pvic_sync.sv
module pvic_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/pvic_sense.sv
module pvic_sense
  import pvic_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int ID_W = $clog2(NSRC)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      raw,
  input  sense_t [NSRC-1:0]    mode,
  input  logic                 ack_valid,
  input  logic [ID_W-1:0]      ack_id,
  output logic [NSRC-1:0]      pend
);
  logic [NSRC-1:0] prev_q;
  logic [NSRC-1:0] edge_q;
  logic [NSRC-1:0] hit;
  logic [NSRC-1:0] acked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= raw;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i]   = mode[i].trig &&
                      (mode[i].inv ? (prev_q[i] && !raw[i]) : (!prev_q[i] && raw[i]));
    assign acked[i] = ack_valid && (ack_id == ID_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              edge_q[i] <= 1'b0;
      else if (!mode[i].trig)  edge_q[i] <= 1'b0;
      else if (hit[i])         edge_q[i] <= 1'b1;
      else if (acked[i])       edge_q[i] <= 1'b0;
    end

    assign pend[i] = mode[i].trig ? edge_q[i] : (raw[i] ^ mode[i].inv);

    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode[i].trig && edge_q[i] && !acked[i] && $stable(mode[i])) |=> edge_q[i]);
    // R9
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (acked[i] && !hit[i]) |=> !edge_q[i]);
  end
endmodule

// File: rtl/pvic_arb.sv
module pvic_arb
  import pvic_pkg::*;
#(
  parameter int NSRC = 8,
  parameter int ID_W = $clog2(NSRC)
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NSRC-1:0]                    req,
  input  logic [NSRC-1:0][PRIO_W-1:0]        prio,
  output logic                               win_valid,
  output logic [ID_W-1:0]                    win_id
);
  logic [PRIO_W-1:0] best;

  // walk from the top index down; ">=" lets a lower index take a tie
  always_comb begin
    win_valid = 1'b0;
    win_id    = '0;
    best      = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req[i] && (!win_valid || prio[i] >= best)) begin
        win_valid = 1'b1;
        win_id    = ID_W'(i);
        best      = prio[i];
      end
    end
  end

  // R3
  any_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    win_valid == (req != '0));

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    // R7
    prio_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && win_valid) |-> (prio[i] <= prio[win_id]));
    // R8
    tie_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req[i] && win_valid && prio[i] == prio[win_id]) |-> (ID_W'(i) >= win_id));
  end
endmodule

// File: rtl/pvic_top.sv
module pvic_top
  import pvic_pkg::*;
#(
  parameter int NUM_INT = 7,
  localparam int NSRC   = NUM_INT + 1,
  localparam int ID_W   = $clog2(NSRC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_INT-1:0] int_req_i,
  input  logic               ext_irq_i,
  input  logic               ext_fiq_i,
  input  logic               reg_we,
  input  logic               reg_re,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  output logic               irq_o,
  output logic               fiq_o
);
  logic [1:0]                   pin_sync;
  logic [NSRC-1:0]              raw;
  logic [NSRC-1:0]              enable_q;
  logic [NSRC-1:0][PRIO_W-1:0]  prio_q;
  sense_t [NSRC-1:0]            mode_q;
  logic [NSRC-1:0]              pend;
  logic                         win_valid;
  logic [ID_W-1:0]              win_id;
  logic                         in_svc_q;
  logic                         vec_rd, ack_valid, eoi_wr, cfg_wr;
  logic [DATA_W-1:0]            cfg_rd;
  logic                         wdata_unused;

  assign wdata_unused = ^{reg_wdata[7:6], reg_wdata[3]};

  pvic_sync #(.W(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .d({ext_fiq_i, ext_irq_i}),
    .q(pin_sync)
  );

  assign fiq_o = pin_sync[1];
  assign raw   = {pin_sync[0], int_req_i};

  assign vec_rd    = reg_re && (reg_addr == ADDR_VECTOR);
  assign ack_valid = vec_rd && irq_o;
  assign eoi_wr    = reg_we && (reg_addr == ADDR_EOI);
  assign cfg_wr    = reg_we && reg_addr[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q <= '0;
      prio_q   <= '0;
      mode_q   <= '0;
    end else begin
      if (reg_we && reg_addr == ADDR_ENABLE)
        enable_q <= reg_wdata[NSRC-1:0];
      for (int i = 0; i < NSRC; i++) begin
        if (cfg_wr && reg_addr[2:0] == 3'(i)) begin
          prio_q[i]      <= reg_wdata[2:0];
          mode_q[i].trig <= reg_wdata[5];
          mode_q[i].inv  <= (i >= NUM_INT) ? reg_wdata[4] : 1'b0;
        end
      end
    end
  end

  pvic_sense #(.NSRC(NSRC), .ID_W(ID_W)) u_sense (
    .clk(clk), .rst_n(rst_n),
    .raw(raw), .mode(mode_q),
    .ack_valid(ack_valid), .ack_id(win_id),
    .pend(pend)
  );

  pvic_arb #(.NSRC(NSRC), .ID_W(ID_W)) u_arb (
    .clk(clk), .rst_n(rst_n),
    .req(pend & enable_q), .prio(prio_q),
    .win_valid(win_valid), .win_id(win_id)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         in_svc_q <= 1'b0;
    else if (ack_valid) in_svc_q <= 1'b1;
    else if (eoi_wr)    in_svc_q <= 1'b0;
  end

  assign irq_o = win_valid && !in_svc_q;

  always_comb begin
    cfg_rd = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (reg_addr[2:0] == 3'(i))
        cfg_rd = {2'b00, mode_q[i].trig, mode_q[i].inv, 1'b0, prio_q[i]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) reg_rdata <= '0;
    else if (reg_re) begin
      if (reg_addr[3])                    reg_rdata <= cfg_rd;
      else if (reg_addr == ADDR_ENABLE)   reg_rdata <= DATA_W'(enable_q);
      else if (reg_addr == ADDR_VECTOR)   reg_rdata <= irq_o ? {1'b1, (DATA_W-1-ID_W)'(0), win_id} : '0;
      else                                reg_rdata <= '0;
    end
  end

  // R2
  fiq_from_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> $past(ext_fiq_i, 2));
  // R9
  ack_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |=> !irq_o);
  // R9
  svc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_svc_q && !eoi_wr) |=> !irq_o);
  // R3
  mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q == '0) |-> !irq_o);
endmodule

// File: tb/pvic_top_bench.sv
module pvic_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] int_req = '0;
  logic       ext_irq = 1'b0;
  logic       ext_fiq = 1'b0;
  logic       we = 1'b0, re = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       irq, fiq;
  int         total = 0, failed = 0;

  always #4 clk = ~clk;

  pvic_top u_pvic_top (
    .clk(clk), .rst_n(rst_n), .int_req_i(int_req), .ext_irq_i(ext_irq),
    .ext_fiq_i(ext_fiq), .reg_we(we), .reg_re(re), .reg_addr(addr),
    .reg_wdata(wdata), .reg_rdata(rdata), .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [7:0] d;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    chk("R1 fiq", {7'd0, fiq}, 8'h00);
    rd(4'd0, d);  chk("R1 enable", d, 8'h00);
    rd(4'd15, d); chk("R1 cfg7", d, 8'h00);
  endtask

  task automatic t_cfg;
    logic [7:0] d;
    wr(4'd0, 8'hA5); rd(4'd0, d); chk("R11 enable rb", d, 8'hA5);
    wr(4'd9, 8'h37); rd(4'd9, d); chk("R11 int cfg bit4 forced", d, 8'h27);
    wr(4'd15, 8'h16); rd(4'd15, d); chk("R11 ext cfg", d, 8'h16);
    wr(4'd9, 8'h00); wr(4'd15, 8'h00); wr(4'd0, 8'h00);
  endtask

  task automatic t_fiq;
    wr(4'd0, 8'hFF);
    int_req = 7'h7F;
    cyc(3);
    chk("R2 irq from internals", {7'd0, irq}, 8'h01);
    chk("R2 internal no fiq", {7'd0, fiq}, 8'h00);
    int_req = '0;
    wr(4'd0, 8'h00);
    ext_fiq = 1'b1;
    cyc(1); chk("R2 fiq after 1 edge", {7'd0, fiq}, 8'h00);
    cyc(1); chk("R2 fiq after 2 edges", {7'd0, fiq}, 8'h01);
    ext_fiq = 1'b0;
    cyc(2); chk("R2 fiq drop", {7'd0, fiq}, 8'h00);
  endtask

  task automatic t_mask_level;
    logic [7:0] d;
    wr(4'd10, 8'h03);
    int_req[2] = 1'b1;
    cyc(1); chk("R3 masked", {7'd0, irq}, 8'h00);
    wr(4'd0, 8'h04); chk("R3 unmask", {7'd0, irq}, 8'h01);
    rd(4'd2, d); chk("R9 vector src2", d, 8'h82);
    chk("R9 irq held low", {7'd0, irq}, 8'h00);
    wr(4'd3, 8'h00); chk("R10 reassert level", {7'd0, irq}, 8'h01);
    int_req[2] = 1'b0;
    #1 chk("R4 level drop", {7'd0, irq}, 8'h00);
    cyc(1);
    rd(4'd2, d); chk("R9 spurious read", d, 8'h00);
    wr(4'd10, 8'h00); wr(4'd0, 8'h00);
  endtask

  task automatic t_edge;
    logic [7:0] d;
    wr(4'd12, 8'h25); wr(4'd0, 8'h10);
    int_req[4] = 1'b1; cyc(1); int_req[4] = 1'b0; cyc(2);
    chk("R5 edge latched", {7'd0, irq}, 8'h01);
    rd(4'd2, d); chk("R5 vector src4", d, 8'h84);
    wr(4'd3, 8'h00); chk("R5 edge cleared by ack", {7'd0, irq}, 8'h00);
    wr(4'd12, 8'h00); wr(4'd0, 8'h00);
  endtask

  task automatic t_prio;
    logic [7:0] d;
    wr(4'd9, 8'h02); wr(4'd13, 8'h06); wr(4'd0, 8'h22);
    int_req[1] = 1'b1; int_req[5] = 1'b1; cyc(1);
    rd(4'd2, d); chk("R7 higher prio wins", d, 8'h85);
    wr(4'd3, 8'h00); int_req[5] = 1'b0; cyc(1);
    rd(4'd2, d); chk("R7 remaining src1", d, 8'h81);
    wr(4'd3, 8'h00); int_req[1] = 1'b0;
    wr(4'd11, 8'h04); wr(4'd14, 8'h04); wr(4'd0, 8'h48);
    int_req[3] = 1'b1; int_req[6] = 1'b1; cyc(1);
    rd(4'd2, d); chk("R8 tie lowest index", d, 8'h83);
    wr(4'd3, 8'h00);
    int_req = '0;
    wr(4'd0, 8'h00);
  endtask

  task automatic t_ext;
    logic [7:0] d;
    wr(4'd15, 8'h01); wr(4'd0, 8'h80);
    ext_irq = 1'b1;
    cyc(1); chk("R6 high level 1 edge", {7'd0, irq}, 8'h00);
    cyc(1); chk("R6 high level 2 edges", {7'd0, irq}, 8'h01);
    ext_irq = 1'b0; cyc(2);
    wr(4'd15, 8'h11); chk("R6 low level active", {7'd0, irq}, 8'h01);
    ext_irq = 1'b1; cyc(2); chk("R6 low level idle", {7'd0, irq}, 8'h00);
    wr(4'd15, 8'h21);
    ext_irq = 1'b0; cyc(3); chk("R6 rising ignores fall", {7'd0, irq}, 8'h00);
    ext_irq = 1'b1;
    cyc(2); chk("R6 rising 2 edges", {7'd0, irq}, 8'h00);
    cyc(1); chk("R6 rising 3 edges", {7'd0, irq}, 8'h01);
    ext_irq = 1'b0; cyc(3); chk("R6 rising held", {7'd0, irq}, 8'h01);
    rd(4'd2, d); chk("R9 vector ext", d, 8'h87);
    wr(4'd3, 8'h00); chk("R10 ext edge done", {7'd0, irq}, 8'h00);
    wr(4'd15, 8'h31);
    ext_irq = 1'b1; cyc(3); chk("R6 falling ignores rise", {7'd0, irq}, 8'h00);
    ext_irq = 1'b0; cyc(3); chk("R6 falling latched", {7'd0, irq}, 8'h01);
    rd(4'd2, d); chk("R6 vector ext fall", d, 8'h87);
    wr(4'd3, 8'h00); chk("R10 no pending left", {7'd0, irq}, 8'h00);
    wr(4'd0, 8'h00);
  endtask

  initial begin
    cyc(3);
    rst_n = 1'b1;
    cyc(1);
    t_reset();
    t_cfg();
    t_fiq();
    t_mask_level();
    t_edge();
    t_prio();
    t_ext();
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule